// File: doc/BRIEF.md
# Firmware Image Loader

This engine takes a firmware image as a stream of 32-bit words on a valid/ready input. It stores the payload in an internal word buffer. When the word marked last has arrived, it checks the image before it writes any target memory. The checks cover the identification word, the byte order, the declared length, the target engine and device fields, the block table, and every block's placement. If all checks pass, the engine copies each code or data block into the instruction or data memory of the target processor through a one-word-per-cycle write port.

A load begins with a `start` pulse and ends with a one-cycle `fin` pulse that carries a 3-bit result code. An image that arrives with the opposite byte order is recognised from its first word. The engine then reverses every later word as it arrives. A load requested while the target processor is running is refused and does not start.

The image layout is as follows. Word 0 is the identification word 0xFEEDF00D. Word 1 is the ID. Word 2 is the payload length P, counted in words, excluding these three. The payload follows. It opens with a table of (type, offset) word pairs. Each offset points, in payload words, to a block made of a target address, a word count N, and then N data words.

Top module: `fw_image_loader`

## Requirements
- R1: After reset, `busy`, `in_ready`, `mem_we`, `fin` and `refused` are all low.
- R2: A `start` while `target_running` is high makes `refused` high for exactly the next cycle. The engine stays idle with `in_ready` low.
- R3: `in_ready` is high from the cycle after an accepted `start` until the word flagged by `in_last` is taken. After that it is low, and no memory write happens while it is high.
- R4: A first word of 0xFEEDF00D loads as is. A first word of 0x0DF0EDFE causes every later word to be byte-reversed. Any other first word ends with code 1.
- R5: If the total word count is not P+3, or P exceeds `BUF_WORDS`, the load ends with code 2. This check comes after the code 1 check.
- R6: The ID is checked after the length. If ID bits 27:24 differ from `engine_id`, or if `legacy_dev` is set and ID bits 31:28 are nonzero, the load ends with code 3.
- R7: The table is scanned at even payload positions 0, 2, 4 and so on. A type word of 0x0000000F ends it. If no end entry lies below position P, the load ends with code 4.
- R8: The table holds n entries before the end entry. An offset below 2n+1, or an offset greater than P-2, ends the load with code 5.
- R9: Type 0 selects instruction memory (`mem_sel`=0) and type 1 selects data memory (`mem_sel`=1). Any other type ends the load with code 6, checked after that entry's offset.
- R10: If address+N exceeds the memory size, the load ends with code 7. Instruction memory holds `MEM_BIG` words, or `MEM_SMALL` words for a legacy device with an engine other than 0. Data memory holds `MEM_SMALL` words on a legacy device and `MEM_BIG` otherwise.
- R11: A block whose end (offset+2+N) lies past P ends with code 2. This check follows the R10 check for the same block.
- R12: A load that ends with any nonzero code makes no memory write.
- R13: A valid image is written block by block in table order, one word per cycle, at ascending addresses. After the last write, `fin` pulses for one cycle with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load |
| target_running | input | 1 | Target processor is running, so a load is refused |
| engine_id | input | 4 | Number of the engine this loader serves |
| legacy_dev | input | 1 | Older device: smaller memories, device field must be zero |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted when high with `in_valid` |
| in_data | input | 32 | Stream word |
| in_last | input | 1 | Marks the final word of the image |
| mem_we | output | 1 | Memory write strobe |
| mem_sel | output | 1 | 0 = instruction memory, 1 = data memory |
| mem_addr | output | 13 | Target word address |
| mem_wdata | output | 32 | Word to write |
| busy | output | 1 | A load is in progress |
| refused | output | 1 | One-cycle pulse: start was refused |
| fin | output | 1 | One-cycle pulse: load finished |
| fin_code | output | 3 | Result with `fin`: 0 ok, 1 identification, 2 length, 3 ID, 4 no end, 5 offset, 6 type, 7 too big |

## Verification
`refused` is due in the cycle right after the refused `start`, and the bench samples it at the next falling edge. `in_ready` is expected to drop in the cycle after the last word is taken, and the bench samples it at the falling edge that follows that word. Memory writes start a variable number of cycles after the stream ends, because the table and block checks take several cycles. The bench therefore queues the expected (memory, address, data) triples and compares each one at the falling edge where `mem_we` is high. When `fin` is seen, the bench compares the result code and requires the queue to be empty, so a missing, extra or reordered write is reported.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

   localparam logic [31:0] IMG_ID_WORD = 32'hFEED_F00D;
   localparam logic [31:0] TBL_END     = 32'h0000_000F;

   typedef enum logic [2:0] {
      FC_OK     = 3'd0,
      FC_MAGIC  = 3'd1,
      FC_SIZE   = 3'd2,
      FC_ID     = 3'd3,
      FC_NOEND  = 3'd4,
      FC_OFFSET = 3'd5,
      FC_TYPE   = 3'd6,
      FC_BIG    = 3'd7
   } fin_code_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RECV,
      S_HDR,
      S_SCAN,
      S_ENT,
      S_BLK,
      S_DAT
   } ld_state_e;

   function automatic logic [31:0] rev_bytes(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

endpackage

// File: rtl/fwl_word_buf.sv
module fwl_word_buf #(
   parameter int DEPTH = 512,
   parameter int AW    = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [31:0]   wd,
   input  logic [AW-1:0] ra_idx,
   output logic [31:0]   ra_data,
   input  logic [AW-1:0] rb_idx,
   output logic [31:0]   rb_data
);

   logic [31:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[wa] <= wd;
   end

   assign ra_data = store[ra_idx];
   assign rb_data = store[rb_idx];

endmodule

// File: rtl/fwl_ingest.sv
module fwl_ingest
   import fwl_pkg::*;
#(
   parameter int DEPTH   = 512,
   parameter int AW      = 9,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          beat,
   input  logic [31:0]   raw,
   output logic [31:0]   tot,
   output logic [7:0]    id_hi,
   output logic [31:0]   size,
   output logic          magic_bad,
   output logic          buf_we,
   output logic [AW-1:0] buf_wa,
   output logic [31:0]   buf_wd
);

   logic [31:0] cnt_q;
   logic        swap_q;
   logic        bad_q;
   logic [7:0]  id_q;
   logic [31:0] size_q;
   logic        is_rev;
   logic [31:0] fixed;
   logic [31:0] pidx;

   generate
      if (SWAP_EN) begin : g_swap
         assign is_rev = (raw == rev_bytes(IMG_ID_WORD));
      end else begin : g_noswap
         assign is_rev = 1'b0;
      end
   endgenerate

   assign fixed = swap_q ? rev_bytes(raw) : raw;
   assign pidx  = cnt_q - 32'd3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         swap_q <= 1'b0;
         bad_q  <= 1'b0;
         id_q   <= '0;
         size_q <= '0;
      end else if (clr) begin
         cnt_q  <= '0;
         swap_q <= 1'b0;
         bad_q  <= 1'b0;
         id_q   <= '0;
         size_q <= '0;
      end else if (beat) begin
         cnt_q <= cnt_q + 32'd1;
         if (cnt_q == 32'd0) begin
            swap_q <= is_rev;
            bad_q  <= !(raw == IMG_ID_WORD || is_rev);
         end
         if (cnt_q == 32'd1) id_q <= fixed[31:24];
         if (cnt_q == 32'd2) size_q <= fixed;
      end
   end

   assign tot       = cnt_q;
   assign id_hi     = id_q;
   assign size      = size_q;
   assign magic_bad = bad_q;
   assign buf_we    = beat && (cnt_q >= 32'd3) && (pidx < 32'(DEPTH));
   assign buf_wa    = pidx[AW-1:0];
   assign buf_wd    = fixed;

endmodule

// File: rtl/fwl_limits.sv
module fwl_limits #(
   parameter int MEM_BIG   = 4096,
   parameter int MEM_SMALL = 2048
) (
   input  logic        legacy,
   input  logic [3:0]  engine,
   output logic [31:0] isize,
   output logic [31:0] dsize
);

   generate
      if (MEM_SMALL == MEM_BIG) begin : g_flat
         assign isize = 32'(MEM_BIG);
         assign dsize = 32'(MEM_BIG);
      end else begin : g_split
         assign isize = (legacy && engine != 4'd0) ? 32'(MEM_SMALL) : 32'(MEM_BIG);
         assign dsize = legacy ? 32'(MEM_SMALL) : 32'(MEM_BIG);
      end
   endgenerate

endmodule

// File: rtl/fwl_seq.sv
module fwl_seq
   import fwl_pkg::*;
#(
   parameter int DEPTH  = 512,
   parameter int AW     = 9,
   parameter int MEM_AW = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              target_running,
   input  logic [3:0]        engine_id,
   input  logic              legacy_dev,
   input  logic              in_valid,
   input  logic              in_last,
   output logic              in_ready,
   output logic              beat,
   output logic              clr,
   input  logic [31:0]       tot,
   input  logic [7:0]        id_hi,
   input  logic [31:0]       size,
   input  logic              magic_bad,
   input  logic [31:0]       isize,
   input  logic [31:0]       dsize,
   output logic [AW-1:0]     ra_idx,
   input  logic [31:0]       ra_data,
   output logic [AW-1:0]     rb_idx,
   input  logic [31:0]       rb_data,
   output logic              mem_we,
   output logic              mem_sel,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic              busy,
   output logic              refused,
   output logic              fin,
   output logic [2:0]        fin_code
);

   ld_state_e        st_q;
   logic [AW:0]      pos_q;
   logic [AW-1:0]    nblk_q;
   logic [AW-1:0]    off_q;
   logic             typ_q;
   logic             pass_q;
   logic [MEM_AW-1:0] baddr_q;
   logic [AW:0]      bcnt_q;
   logic [AW:0]      j_q;
   logic             fin_q;
   logic             ref_q;
   fin_code_e        code_q;

   logic             fin_now;
   fin_code_e        fin_c;
   logic             at_end;
   logic             size_bad, id_bad, off_bad, type_bad, too_big, overrun;
   logic [31:0]      lim;
   logic [AW:0]      tend;

   assign in_ready = (st_q == S_RECV);
   assign beat     = in_ready && in_valid;
   assign clr      = (st_q == S_IDLE) && start && !target_running;
   assign busy     = (st_q != S_IDLE);
   assign tend     = {nblk_q, 1'b1};
   assign at_end   = (pos_q == {nblk_q, 1'b0});
   assign lim      = typ_q ? dsize : isize;

   assign size_bad = ({1'b0, tot} != ({1'b0, size} + 33'd3)) || (size > 32'(DEPTH));
   assign id_bad   = (id_hi[3:0] != engine_id) || (legacy_dev && id_hi[7:4] != 4'd0);
   assign off_bad  = ({1'b0, rb_data} < 33'(tend)) || (({1'b0, rb_data} + 33'd2) > {1'b0, size});
   assign type_bad = (ra_data > 32'd1);
   assign too_big  = (({1'b0, ra_data} + {1'b0, rb_data}) > {1'b0, lim});
   assign overrun  = (({1'b0, rb_data} + 33'(off_q) + 33'd2) > {1'b0, size});

   always_comb begin
      ra_idx = '0;
      rb_idx = '0;
      case (st_q)
         S_SCAN, S_ENT: begin
            ra_idx = pos_q[AW-1:0];
            rb_idx = pos_q[AW-1:0] + AW'(1);
         end
         S_BLK: begin
            ra_idx = off_q;
            rb_idx = off_q + AW'(1);
         end
         S_DAT: begin
            ra_idx = AW'(32'(off_q) + 32'd2 + 32'(j_q));
         end
         default: ;
      endcase
   end

   always_comb begin
      fin_now = 1'b0;
      fin_c   = FC_OK;
      case (st_q)
         S_HDR: begin
            if (magic_bad) begin
               fin_now = 1'b1; fin_c = FC_MAGIC;
            end else if (size_bad) begin
               fin_now = 1'b1; fin_c = FC_SIZE;
            end else if (id_bad) begin
               fin_now = 1'b1; fin_c = FC_ID;
            end
         end
         S_SCAN: begin
            if (32'(pos_q) >= size) begin
               fin_now = 1'b1; fin_c = FC_NOEND;
            end
         end
         S_ENT: begin
            if (at_end) begin
               if (pass_q) fin_now = 1'b1;
            end else if (off_bad) begin
               fin_now = 1'b1; fin_c = FC_OFFSET;
            end else if (type_bad) begin
               fin_now = 1'b1; fin_c = FC_TYPE;
            end
         end
         S_BLK: begin
            if (too_big) begin
               fin_now = 1'b1; fin_c = FC_BIG;
            end else if (overrun) begin
               fin_now = 1'b1; fin_c = FC_SIZE;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         pos_q   <= '0;
         nblk_q  <= '0;
         off_q   <= '0;
         typ_q   <= 1'b0;
         pass_q  <= 1'b0;
         baddr_q <= '0;
         bcnt_q  <= '0;
         j_q     <= '0;
         fin_q   <= 1'b0;
         ref_q   <= 1'b0;
         code_q  <= FC_OK;
      end else begin
         fin_q <= 1'b0;
         ref_q <= 1'b0;
         if (fin_now) begin
            fin_q  <= 1'b1;
            code_q <= fin_c;
            st_q   <= S_IDLE;
         end else begin
            case (st_q)
               S_IDLE: begin
                  if (start) begin
                     if (target_running) ref_q <= 1'b1;
                     else                st_q  <= S_RECV;
                  end
               end
               S_RECV: begin
                  if (beat && in_last) st_q <= S_HDR;
               end
               S_HDR: begin
                  pos_q <= '0;
                  st_q  <= S_SCAN;
               end
               S_SCAN: begin
                  if (ra_data == TBL_END) begin
                     nblk_q <= pos_q[AW:1];
                     pos_q  <= '0;
                     pass_q <= 1'b0;
                     st_q   <= S_ENT;
                  end else begin
                     pos_q <= pos_q + (AW+1)'(2);
                  end
               end
               S_ENT: begin
                  if (at_end) begin
                     pass_q <= 1'b1;
                     pos_q  <= '0;
                  end else begin
                     off_q <= rb_data[AW-1:0];
                     typ_q <= ra_data[0];
                     st_q  <= S_BLK;
                  end
               end
               S_BLK: begin
                  baddr_q <= ra_data[MEM_AW-1:0];
                  bcnt_q  <= rb_data[AW:0];
                  j_q     <= '0;
                  if (pass_q && rb_data != 32'd0) begin
                     st_q <= S_DAT;
                  end else begin
                     pos_q <= pos_q + (AW+1)'(2);
                     st_q  <= S_ENT;
                  end
               end
               S_DAT: begin
                  j_q <= j_q + (AW+1)'(1);
                  if (j_q == bcnt_q - (AW+1)'(1)) begin
                     pos_q <= pos_q + (AW+1)'(2);
                     st_q  <= S_ENT;
                  end
               end
               default: st_q <= S_IDLE;
            endcase
         end
      end
   end

   assign mem_we    = (st_q == S_DAT);
   assign mem_sel   = typ_q;
   assign mem_addr  = baddr_q + MEM_AW'(j_q);
   assign mem_wdata = ra_data;
   assign refused   = ref_q;
   assign fin       = fin_q;
   assign fin_code  = code_q;

   // checker state: any write since the load was accepted
   logic wrote_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wrote_q <= 1'b0;
      else if (clr)    wrote_q <= 1'b0;
      else if (mem_we) wrote_q <= 1'b1;
   end

   AST_REFUSE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      refused |-> (!busy && $past(start && target_running))); // R2

   AST_NO_WR_DURING_RECV: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !mem_we); // R3

   AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (32'(mem_addr) < (mem_sel ? dsize : isize))); // R10

   AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && fin_code != 3'd0) |-> !wrote_q); // R12

   AST_WR_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + MEM_AW'(1) && mem_sel == $past(mem_sel))); // R13

   AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin); // R13

endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader
   import fwl_pkg::*;
#(
   parameter int BUF_WORDS = 512,
   parameter int MEM_BIG   = 4096,
   parameter int MEM_SMALL = 2048,
   parameter bit SWAP_EN   = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic                           target_running,
   input  logic [3:0]                     engine_id,
   input  logic                           legacy_dev,
   input  logic                           in_valid,
   output logic                           in_ready,
   input  logic [31:0]                    in_data,
   input  logic                           in_last,
   output logic                           mem_we,
   output logic                           mem_sel,
   output logic [$clog2(MEM_BIG+1)-1:0]   mem_addr,
   output logic [31:0]                    mem_wdata,
   output logic                           busy,
   output logic                           refused,
   output logic                           fin,
   output logic [2:0]                     fin_code
);

   localparam int AW     = $clog2(BUF_WORDS);
   localparam int MEM_AW = $clog2(MEM_BIG + 1);

   generate
      if (BUF_WORDS < 512) begin : g_chk_depth
         $error("BUF_WORDS must be at least 512");
      end
      if ((1 << AW) != BUF_WORDS) begin : g_chk_pow2
         $error("BUF_WORDS must be a power of two");
      end
      if (MEM_SMALL > MEM_BIG) begin : g_chk_mem
         $error("MEM_SMALL must not exceed MEM_BIG");
      end
   endgenerate

   logic          beat, clr;
   logic [31:0]   tot, size;
   logic [7:0]    id_hi;
   logic          magic_bad;
   logic          buf_we;
   logic [AW-1:0] buf_wa;
   logic [31:0]   buf_wd;
   logic [AW-1:0] ra_idx, rb_idx;
   logic [31:0]   ra_data, rb_data;
   logic [31:0]   isize, dsize;

   fwl_ingest #(.DEPTH(BUF_WORDS), .AW(AW), .SWAP_EN(SWAP_EN)) u_ingest (
      .clk(clk), .rst_n(rst_n), .clr(clr), .beat(beat), .raw(in_data),
      .tot(tot), .id_hi(id_hi), .size(size), .magic_bad(magic_bad),
      .buf_we(buf_we), .buf_wa(buf_wa), .buf_wd(buf_wd)
   );

   fwl_word_buf #(.DEPTH(BUF_WORDS), .AW(AW)) u_buf (
      .clk(clk), .we(buf_we), .wa(buf_wa), .wd(buf_wd),
      .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data)
   );

   fwl_limits #(.MEM_BIG(MEM_BIG), .MEM_SMALL(MEM_SMALL)) u_lim (
      .legacy(legacy_dev), .engine(engine_id), .isize(isize), .dsize(dsize)
   );

   fwl_seq #(.DEPTH(BUF_WORDS), .AW(AW), .MEM_AW(MEM_AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .target_running(target_running),
      .engine_id(engine_id), .legacy_dev(legacy_dev),
      .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
      .beat(beat), .clr(clr),
      .tot(tot), .id_hi(id_hi), .size(size), .magic_bad(magic_bad),
      .isize(isize), .dsize(dsize),
      .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
      .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .busy(busy), .refused(refused), .fin(fin), .fin_code(fin_code)
   );

endmodule

// File: tb/sim_fw_image_loader.sv
`timescale 1ns/1ps
module sim_fw_image_loader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        target_running = 1'b0;
   logic [3:0]  engine_id = 4'd1;
   logic        legacy_dev = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        in_last = 1'b0;
   logic        mem_we, mem_sel;
   logic [12:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        busy, refused, fin;
   logic [2:0]  fin_code;

   always #2 clk = ~clk;

   fw_image_loader u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .target_running(target_running),
      .engine_id(engine_id), .legacy_dev(legacy_dev),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .busy(busy), .refused(refused), .fin(fin), .fin_code(fin_code)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   int          fin_cnt = 0;
   logic [2:0]  exp_code = 3'd0;
   string       exp_req = "R13";
   logic        prev_fin = 1'b0;
   logic [45:0] sb[$];
   logic [31:0] pl[$];
   logic [31:0] img[$];

   function automatic logic [31:0] rb(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic ew(input logic sel, input logic [12:0] a, input logic [31:0] d);
      sb.push_back({sel, a, d});
   endtask

   task automatic mkimg(input logic [31:0] magic, input logic [31:0] id,
                        input int adj, input bit swap);
      img.delete();
      img.push_back(magic);
      img.push_back(id);
      img.push_back(32'(pl.size() + adj));
      foreach (pl[i]) img.push_back(pl[i]);
      if (swap) foreach (img[i]) img[i] = rb(img[i]);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R12", "write with nothing expected", {mem_sel, mem_addr, mem_wdata}, 0);
            end else begin
               logic [45:0] e;
               e = sb.pop_front();
               chk({mem_sel, mem_addr, mem_wdata} == e, "R13", "write triple",
                   {mem_sel, mem_addr, mem_wdata}, e);
            end
         end
         if (fin) begin
            chk(fin_code == exp_code, exp_req, "fin_code", fin_code, exp_code);
            chk(sb.size() == 0, "R13", "writes still pending at fin", sb.size(), 0);
            sb.delete();
            fin_cnt++;
         end
         if (fin && prev_fin) chk(1'b0, "R13", "fin wider than one cycle", 2, 1);
         prev_fin = fin;
      end
   end

   task automatic run(input logic [2:0] code, input string req, input bit gap);
      int f0;
      f0 = fin_cnt;
      exp_code = code;
      exp_req = req;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int i = 0; i < img.size(); i++) begin
         if (gap && (i % 4) == 2) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         while (!in_ready) @(negedge clk);
         in_valid = 1'b1;
         in_data  = img[i];
         in_last  = (i == img.size() - 1);
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
      chk(in_ready == 1'b0, "R3", "in_ready after last word", in_ready, 0);
      while (fin_cnt == f0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic std_payload();
      pl = '{32'd0, 32'd6, 32'd1, 32'd11, 32'hF, 32'd0,
             32'h10, 32'd3, 32'hA1, 32'hB2, 32'hC3,
             32'h7FE, 32'd2, 32'hD4, 32'hE5};
   endtask

   task automatic std_writes();
      ew(1'b0, 13'h10, 32'hA1);
      ew(1'b0, 13'h11, 32'hB2);
      ew(1'b0, 13'h12, 32'hC3);
      ew(1'b1, 13'h7FE, 32'hD4);
      ew(1'b1, 13'h7FF, 32'hE5);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !in_ready && !mem_we && !fin && !refused, "R1", "idle outputs",
          {busy, in_ready, mem_we, fin, refused}, 0);

      // R2 refused while running
      target_running = 1'b1;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(refused == 1'b1, "R2", "refused pulse", refused, 1);
      chk(in_ready == 1'b0 && busy == 1'b0, "R2", "stays idle", {in_ready, busy}, 0);
      @(negedge clk);
      chk(refused == 1'b0, "R2", "refused one cycle", refused, 0);
      target_running = 1'b0;

      // R13 normal image, R9 types select memories
      std_payload(); mkimg(32'hFEEDF00D, 32'h0100_0000, 0, 1'b0);
      std_writes(); run(3'd0, "R13", 1'b0);

      // R4 byte-reversed image, with bubbles in valid
      std_payload(); mkimg(32'hFEEDF00D, 32'h0100_0000, 0, 1'b1);
      std_writes(); run(3'd0, "R4", 1'b1);

      // R4 bad identification word
      std_payload(); mkimg(32'h1234_5678, 32'h0100_0000, 0, 1'b0);
      run(3'd1, "R4", 1'b0);

      // R5 size field off by one
      std_payload(); mkimg(32'hFEEDF00D, 32'h0100_0000, 1, 1'b0);
      run(3'd2, "R5", 1'b0);

      // R5 payload larger than buffer
      pl.delete(); pl.push_back(32'hF);
      for (int i = 1; i < 520; i++) pl.push_back(32'd0);
      mkimg(32'hFEEDF00D, 32'h0100_0000, 0, 1'b0);
      run(3'd2, "R5", 1'b0);

      // R6 engine mismatch
      std_payload(); mkimg(32'hFEEDF00D, 32'h0200_0000, 0, 1'b0);
      run(3'd3, "R6", 1'b0);

      // R6 device field on legacy device
      legacy_dev = 1'b1;
      std_payload(); mkimg(32'hFEEDF00D, 32'h1100_0000, 0, 1'b0);
      run(3'd3, "R6", 1'b0);
      legacy_dev = 1'b0;

      // R6 device field accepted when not legacy
      std_payload(); mkimg(32'hFEEDF00D, 32'h1100_0000, 0, 1'b0);
      std_writes(); run(3'd0, "R6", 1'b0);

      // R7 no end entry
      pl = '{32'd0, 32'd4, 32'd0, 32'd4, 32'd0, 32'd1, 32'd5};
      mkimg(32'hFEEDF00D, 32'h0100_0000, 0, 1'b0);
      run(3'd4, "R7", 1'b0);

      // R8 offset inside table
      pl = '{32'd0, 32'd2, 32'hF, 32'd0, 32'd0, 32'd1, 32'd7};
      mkimg(32'hFEEDF00D, 32'h0100_0000, 0, 1'b0);
      run(3'd5, "R8", 1'b0);

      // R8 offset above P-2
      pl = '{32'd0, 32'd6, 32'hF, 32'd0, 32'd0, 32'd1, 32'd7};
      mkimg(32'hFEEDF00D, 32'h0100_0000, 0, 1'b0);
      run(3'd5, "R8", 1'b0);

      // R8 offset exactly P-2 with an empty block: accepted, nothing written
      pl = '{32'd0, 32'd5, 32'hF, 32'd0, 32'd0, 32'd0, 32'd0};
      mkimg(32'hFEEDF00D, 32'h0100_0000, 0, 1'b0);
      run(3'd0, "R8", 1'b0);

      // R9 and R12 bad type on second entry, first entry valid
      pl = '{32'd0, 32'd6, 32'd2, 32'd6, 32'hF, 32'd0, 32'd0, 32'd1, 32'd9};
      mkimg(32'hFEEDF00D, 32'h0100_0000, 0, 1'b0);
      run(3'd6, "R9", 1'b0);

      // R10 legacy engine 1: instruction limit 0x800 exceeded
      legacy_dev = 1'b1;
      pl = '{32'd0, 32'd4, 32'hF, 32'd0, 32'h7FF, 32'd2, 32'h11, 32'h22};
      mkimg(32'hFEEDF00D, 32'h0100_0000, 0, 1'b0);
      run(3'd7, "R10", 1'b0);

      // R10 legacy engine 1: data block ending exactly at 0x800 accepted
      std_payload(); mkimg(32'hFEEDF00D, 32'h0100_0000, 0, 1'b0);
      std_writes(); run(3'd0, "R10", 1'b0);

      // R10 legacy engine 0 has the large instruction memory
      engine_id = 4'd0;
      pl = '{32'd0, 32'd4, 32'hF, 32'd0, 32'h7FF, 32'd2, 32'h11, 32'h22};
      mkimg(32'hFEEDF00D, 32'h0000_0000, 0, 1'b0);
      ew(1'b0, 13'h7FF, 32'h11);
      ew(1'b0, 13'h800, 32'h22);
      run(3'd0, "R10", 1'b0);
      engine_id = 4'd1;
      legacy_dev = 1'b0;

      // R11 block runs past payload
      pl = '{32'd0, 32'd4, 32'hF, 32'd0, 32'd0, 32'd5, 32'd1, 32'd2};
      mkimg(32'hFEEDF00D, 32'h0100_0000, 0, 1'b0);
      run(3'd2, "R11", 1'b0);

      // R7 table with only the end entry
      pl = '{32'hF, 32'd0};
      mkimg(32'hFEEDF00D, 32'h0100_0000, 0, 1'b0);
      run(3'd0, "R7", 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule